// File: doc/BRIEF.md
# Configuration readback frame serializer

This block streams a set of stored configuration frames out of one serial data pin. The pace is set by a clock that an outside tester drives. A low-to-high edge on the trigger input starts a readback. After that, every rising edge of the external readback clock moves the output on by one bit. The stream opens with leading filler bits. Then come the frames, in address order, each wrapped in a start bit and a stop bit, with every data bit inverted. Certain bit positions in each frame are never used for configuration. During readback those positions carry the live value of an outside storage element, sampled at the moment the bit is shifted.

The frames sit in a small synchronous memory that is written while the device is configured. A two-bit permission setting, fixed at configuration time, decides whether a readback may start at all. The readback clock and the trigger are both sampled by the system clock, so the whole block runs in one clock domain. The busy output marks the time during which the shared mode and clock pins are taken over by readback. When busy falls, those pins go back to their normal use, and a one-cycle completion pulse marks that moment.

Top module: `rbk_serializer`

## Requirements
- R1: When `rb_trig` goes from low to high, the block is idle and the permission setting allows it, readback starts: `busy` is high within six system clocks of the trigger edge.
- R2: The first two rising edges of `rb_clk` after acceptance each drive `rb_data` to 1 as filler. The third edge also drives 1, and this bit is the start bit of frame 0.
- R3: Frames 0 to NUM_FRAMES-1 are sent in address order. Each frame is a start bit of 1, then FRAME_BITS data bits with position 0 first, then a single stop bit of 0. Frame f holds the word last written with `cfg_we` high and `cfg_addr` equal to f.
- R4: Every data bit is sent inverted: a stored 0 appears on `rb_data` as 1, and a stored 1 appears as 0.
- R5: A data position p is a live position when p mod LIVE_STRIDE equals LIVE_STRIDE-1. At a live position, frame f sends the inverse of `live_state[f*(FRAME_BITS/LIVE_STRIDE) + p/LIVE_STRIDE]`, and the stored bit at that position is not used.
- R6: `busy` stays high from acceptance until the rb_clk edge that shifts the final stop bit, and goes low on that edge. `done` is high for exactly one system clock at that point, and only then.
- R7: A trigger edge that arrives while a readback is in progress is ignored and does not change the stream. This includes a trigger seen in the same cycle as the final stop bit; after that edge the block stays idle.
- R8: With `perm_mode` = 2'b00 (never), no trigger starts a readback.
- R9: With `perm_mode` = 2'b01 (one-time), the first readback runs. After it completes, no trigger starts a readback until reset.
- R10: With `perm_mode` = 2'b10 or 2'b11 (on-command), any number of readbacks may be run back to back.
- R11: After reset, `busy`, `done` and `rb_data` are 0. While the block is idle, `rb_data` stays 0 and rising edges of `rb_clk` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| perm_mode | input | 2 | Readback permission: 00 never, 01 one-time, 10/11 on-command |
| cfg_we | input | 1 | Frame memory write enable |
| cfg_addr | input | AW | Frame index to write |
| cfg_wdata | input | FRAME_BITS | Frame word to write |
| live_state | input | NUM_FRAMES*FRAME_BITS/LIVE_STRIDE | Live storage-element values for the live bit positions |
| rb_trig | input | 1 | Read trigger; a rising edge requests a readback |
| rb_clk | input | 1 | External readback clock; each rising edge shifts one bit |
| rb_data | output | 1 | Serial readback data |
| busy | output | 1 | Readback in progress; the shared pins are taken |
| done | output | 1 | One-cycle pulse when the final stop bit is shifted |

## Verification
Both inputs pass through synchronizers of the same depth. A trigger edge and a readback-clock edge can therefore be seen in the same system cycle. The case that matters is a trigger arriving together with the edge that shifts the last stop bit. The bench raises `rb_trig` and `rb_clk` on the same falling clock edge, in the final bit and also in the middle of a frame. It then checks that the stream was not disturbed, that `busy` goes low, and that more `rb_clk` edges leave `rb_data` at 0. That shows the trigger was dropped rather than restarting the sequence.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LEAD  = 3'd1,
    PH_START = 3'd2,
    PH_DATA  = 3'd3,
    PH_STOP  = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    PERM_NEVER   = 2'b00,
    PERM_ONCE    = 2'b01,
    PERM_CMD     = 2'b10,
    PERM_CMD_ALT = 2'b11
  } perm_e;

  // A data position carries a live state bit when it is the last one of its stride group.
  function automatic logic pos_is_live(input int unsigned pos, input int unsigned stride);
    return (pos % stride) == (stride - 1);
  endfunction

  // Index into the flat live-state vector for a given frame and data position.
  function automatic int unsigned live_slot(input int unsigned frame, input int unsigned pos,
                                            input int unsigned stride, input int unsigned per_frame);
    return frame * per_frame + pos / stride;
  endfunction

  // Decides whether a trigger may start a readback.
  function automatic logic perm_allows(input logic [1:0] mode, input logic used);
    logic ok;
    case (mode)
      PERM_NEVER: ok = 1'b0;
      PERM_ONCE:  ok = !used;
      default:    ok = 1'b1;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/rbk_sync_edge.sv
module rbk_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/rbk_frame_mem.sv
module rbk_frame_mem #(
  parameter int unsigned NUM_FRAMES = 4,
  parameter int unsigned FRAME_BITS = 8,
  parameter int unsigned AW         = 2
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  logic [FRAME_BITS-1:0] wdata,
  input  logic                  re,
  input  logic [AW-1:0]         raddr,
  output logic [FRAME_BITS-1:0] rdata
);

  logic [FRAME_BITS-1:0] store [NUM_FRAMES];

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
    if (re) begin
      rdata <= store[raddr];
    end
  end

endmodule

// File: rtl/rbk_permit.sv
module rbk_permit
  import rbk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] perm_mode,
  input  logic       finished,
  output logic       perm_ok
);

  logic used_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= 1'b0;
    end else if (finished) begin
      used_q <= 1'b1;
    end
  end

  assign perm_ok = perm_allows(perm_mode, used_q);

endmodule

// File: rtl/rbk_sequencer.sv
module rbk_sequencer
  import rbk_pkg::*;
#(
  parameter int unsigned NUM_FRAMES  = 4,
  parameter int unsigned FRAME_BITS  = 8,
  parameter int unsigned LIVE_STRIDE = 4,
  parameter int unsigned AW          = 2,
  parameter int unsigned NUM_LIVE    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trig_rise,
  input  logic                  step,
  input  logic                  perm_ok,
  input  logic [FRAME_BITS-1:0] frame_word,
  input  logic [NUM_LIVE-1:0]   live_state,
  output logic                  rd_en,
  output logic [AW-1:0]         rd_addr,
  output logic                  rb_data,
  output logic                  busy,
  output logic                  done,
  output logic                  accept,
  output logic                  step_is_start,
  output logic                  step_is_stop
);

  localparam int unsigned BW  = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam int unsigned LPF = FRAME_BITS / LIVE_STRIDE;
  localparam int unsigned LW  = (NUM_LIVE > 1) ? $clog2(NUM_LIVE) : 1;

  phase_e        phase_q;
  logic          lead_q;
  logic [BW-1:0] bit_q;
  logic [AW-1:0] frame_q;

  logic          last_bit;
  logic          last_frame;
  logic          live_hit;
  logic [LW-1:0] slot;
  logic          data_bit;

  assign last_bit   = bit_q == BW'(FRAME_BITS - 1);
  assign last_frame = frame_q == AW'(NUM_FRAMES - 1);

  always_comb begin
    live_hit = pos_is_live(32'(bit_q), LIVE_STRIDE);
    slot     = LW'(live_slot(32'(frame_q), 32'(bit_q), LIVE_STRIDE, LPF));
    data_bit = live_hit ? live_state[slot] : frame_word[bit_q];
  end

  assign busy          = phase_q != PH_IDLE;
  assign accept        = trig_rise && (phase_q == PH_IDLE) && perm_ok;
  assign step_is_start = step && (phase_q == PH_START);
  assign step_is_stop  = step && (phase_q == PH_STOP);

  // Frame 0 is fetched on acceptance; each later frame is fetched at the previous stop bit.
  assign rd_en   = accept || (step_is_stop && !last_frame);
  assign rd_addr = accept ? '0 : frame_q + AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      lead_q  <= 1'b0;
      bit_q   <= '0;
      frame_q <= '0;
      rb_data <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            phase_q <= PH_LEAD;
            lead_q  <= 1'b0;
            bit_q   <= '0;
            frame_q <= '0;
          end
        end
        PH_LEAD: begin
          if (step) begin
            rb_data <= 1'b1;
            if (lead_q) begin
              phase_q <= PH_START;
            end else begin
              lead_q <= 1'b1;
            end
          end
        end
        PH_START: begin
          if (step) begin
            rb_data <= 1'b1;
            bit_q   <= '0;
            phase_q <= PH_DATA;
          end
        end
        PH_DATA: begin
          if (step) begin
            rb_data <= ~data_bit;
            if (last_bit) begin
              phase_q <= PH_STOP;
            end else begin
              bit_q <= bit_q + BW'(1);
            end
          end
        end
        PH_STOP: begin
          if (step) begin
            rb_data <= 1'b0;
            if (last_frame) begin
              phase_q <= PH_IDLE;
              done    <= 1'b1;
            end else begin
              frame_q <= frame_q + AW'(1);
              phase_q <= PH_START;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rbk_serializer.sv
module rbk_serializer
  import rbk_pkg::*;
#(
  parameter int unsigned NUM_FRAMES  = 4,
  parameter int unsigned FRAME_BITS  = 8,
  parameter int unsigned LIVE_STRIDE = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW         = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int unsigned NUM_LIVE   = NUM_FRAMES * (FRAME_BITS / LIVE_STRIDE)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            perm_mode,
  input  logic                  cfg_we,
  input  logic [AW-1:0]         cfg_addr,
  input  logic [FRAME_BITS-1:0] cfg_wdata,
  input  logic [NUM_LIVE-1:0]   live_state,
  input  logic                  rb_trig,
  input  logic                  rb_clk,
  output logic                  rb_data,
  output logic                  busy,
  output logic                  done
);

  logic                  trig_rise;
  logic                  rb_step;
  logic                  perm_ok;
  logic                  accept;
  logic                  step_is_start;
  logic                  step_is_stop;
  logic                  rd_en;
  logic [AW-1:0]         rd_addr;
  logic [FRAME_BITS-1:0] frame_word;

  rbk_sync_edge #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .async_in(rb_trig), .rise(trig_rise)
  );

  rbk_sync_edge #(.STAGES(SYNC_STAGES)) u_clk_sync (
    .clk(clk), .rst_n(rst_n), .async_in(rb_clk), .rise(rb_step)
  );

  rbk_frame_mem #(.NUM_FRAMES(NUM_FRAMES), .FRAME_BITS(FRAME_BITS), .AW(AW)) u_mem (
    .clk(clk), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .re(rd_en), .raddr(rd_addr), .rdata(frame_word)
  );

  rbk_permit u_permit (
    .clk(clk), .rst_n(rst_n), .perm_mode(perm_mode), .finished(done), .perm_ok(perm_ok)
  );

  rbk_sequencer #(
    .NUM_FRAMES(NUM_FRAMES), .FRAME_BITS(FRAME_BITS), .LIVE_STRIDE(LIVE_STRIDE),
    .AW(AW), .NUM_LIVE(NUM_LIVE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .trig_rise(trig_rise), .step(rb_step), .perm_ok(perm_ok),
    .frame_word(frame_word), .live_state(live_state), .rd_en(rd_en), .rd_addr(rd_addr),
    .rb_data(rb_data), .busy(busy), .done(done), .accept(accept),
    .step_is_start(step_is_start), .step_is_stop(step_is_stop)
  );

endmodule

// File: rtl/rbk_serializer_chk.sv
module rbk_serializer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] perm_mode,
  input logic       busy,
  input logic       done,
  input logic       rb_data,
  input logic       trig_rise,
  input logic       step,
  input logic       accept,
  input logic       step_is_start,
  input logic       step_is_stop
);

  assert_start_needs_trigger_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trig_rise));

  assert_start_bit_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_is_start |=> rb_data);

  assert_stop_bit_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_is_stop |=> !rb_data);

  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step) |=> busy);

  assert_busy_end_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy);

  assert_never_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_mode == 2'b00 && !busy) |=> !busy);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rb_data);

endmodule

bind rbk_serializer rbk_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .perm_mode(perm_mode), .busy(busy), .done(done),
  .rb_data(rb_data), .trig_rise(trig_rise), .step(rb_step), .accept(accept),
  .step_is_start(step_is_start), .step_is_stop(step_is_stop)
);

// File: tb/rbk_serializer_test.sv
module rbk_serializer_test;

  localparam int NF = 4;
  localparam int FB = 8;
  localparam int ST = 4;
  localparam int LPF = FB / ST;
  localparam int NL = NF * LPF;
  localparam int TOTAL = 2 + NF * (FB + 2);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    perm_mode = 2'b10;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [FB-1:0] cfg_wdata = '0;
  logic [NL-1:0] live_state = '0;
  logic          rb_trig = 1'b0;
  logic          rb_clk = 1'b0;
  logic          rb_data;
  logic          busy;
  logic          done;

  int vectors = 0;
  int miscompares = 0;
  int done_cnt = 0;
  int cyc = 0;
  logic [FB-1:0] mem_tb [NF];

  rbk_serializer #(.NUM_FRAMES(NF), .FRAME_BITS(FB), .LIVE_STRIDE(ST)) uut (
    .clk(clk), .rst_n(rst_n), .perm_mode(perm_mode), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .live_state(live_state), .rb_trig(rb_trig), .rb_clk(rb_clk),
    .rb_data(rb_data), .busy(busy), .done(done)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && done) done_cnt <= done_cnt + 1;
    if (cyc > 150000) begin
      miscompares = miscompares + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check(input logic got, input logic exp, input string tag);
    vectors = vectors + 1;
    if (got !== exp) begin
      miscompares = miscompares + 1;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic check_int(input int got, input int exp, input string tag);
    vectors = vectors + 1;
    if (got != exp) begin
      miscompares = miscompares + 1;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Expected stream bit for rb_clk edge n, taken from R2..R5.
  function automatic logic exp_bit(input int n);
    int m, f, p, d;
    if (n < 2) return 1'b1;
    m = n - 2;
    f = m / (FB + 2);
    p = m % (FB + 2);
    if (p == 0) return 1'b1;
    if (p == FB + 1) return 1'b0;
    d = p - 1;
    if (d % ST == ST - 1) return ~live_state[f * LPF + d / ST];
    return ~mem_tb[f][d];
  endfunction

  function automatic string bit_tag(input int n);
    int m, p;
    if (n < 2) return "R2 dummy";
    if (n == 2) return "R2 first start";
    m = n - 2;
    p = m % (FB + 2);
    if (p == 0) return "R3 start";
    if (p == FB + 1) return "R3 stop";
    if ((p - 1) % ST == ST - 1) return "R5 live";
    return "R4 data";
  endfunction

  task automatic do_reset(input logic [1:0] mode);
    @(negedge clk);
    perm_mode = mode;
    rst_n = 1'b0;
    rb_trig = 1'b0;
    rb_clk = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic load_frames(input logic [FB-1:0] w0, input logic [FB-1:0] w1,
                             input logic [FB-1:0] w2, input logic [FB-1:0] w3);
    mem_tb[0] = w0; mem_tb[1] = w1; mem_tb[2] = w2; mem_tb[3] = w3;
    for (int i = 0; i < NF; i++) begin
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_addr = 2'(i);
      cfg_wdata = mem_tb[i];
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk);
    rb_trig = 1'b1;
    repeat (6) @(negedge clk);
    rb_trig = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // One rb_clk rising edge, optionally with a trigger edge in the same instant.
  task automatic pulse_rb(input logic with_trig, output logic got);
    @(negedge clk);
    rb_clk = 1'b1;
    if (with_trig) rb_trig = 1'b1;
    repeat (6) @(negedge clk);
    got = rb_data;
    rb_clk = 1'b0;
    rb_trig = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // Full readback; a trigger is injected together with edge inject_at (-1 for none).
  task automatic run_readback(input int inject_at, input string label);
    int   d0;
    logic got;
    d0 = done_cnt;
    pulse_trig();
    check(busy, 1'b1, {"R1 busy after trigger ", label});
    for (int n = 0; n < TOTAL; n++) begin
      if (n == TOTAL - 1) check(busy, 1'b1, {"R6 busy before final stop ", label});
      pulse_rb(n == inject_at, got);
      check(got, exp_bit(n), {bit_tag(n), " ", label});
    end
    check(busy, 1'b0, {"R6 busy after final stop ", label});
    check_int(done_cnt - d0, 1, {"R6 done pulse count ", label});
  endtask

  task automatic t_reset();
    do_reset(2'b10);
    check(busy, 1'b0, "R11 busy after reset");
    check(done, 1'b0, "R11 done after reset");
    check(rb_data, 1'b0, "R11 rb_data after reset");
  endtask

  task automatic t_idle_edges();
    logic got;
    for (int i = 0; i < 3; i++) begin
      pulse_rb(1'b0, got);
      check(got, 1'b0, "R11 rb_data idle edge");
      check(busy, 1'b0, "R11 busy idle edge");
    end
  endtask

  task automatic t_on_command();
    load_frames(8'hA5, 8'h3C, 8'hF0, 8'h0F);
    live_state = 8'b1100_1010;
    run_readback(-1, "R10 cmd pass1");
    load_frames(8'h00, 8'hFF, 8'h81, 8'h7E);
    live_state = 8'h35;
    run_readback(-1, "R10 cmd pass2");
    perm_mode = 2'b11;
    live_state = 8'hFF;
    run_readback(-1, "R10 cmd alt encoding");
  endtask

  task automatic t_busy_trigger();
    logic got;
    load_frames(8'h5A, 8'hC3, 8'h96, 8'h69);
    live_state = 8'h4E;
    run_readback(15, "R7 trigger mid frame");
    run_readback(TOTAL - 1, "R7 trigger at final stop");
    pulse_rb(1'b0, got);
    check(got, 1'b0, "R7 no restart rb_data");
    check(busy, 1'b0, "R7 no restart busy");
  endtask

  task automatic t_never();
    logic got;
    do_reset(2'b00);
    pulse_trig();
    check(busy, 1'b0, "R8 never blocks trigger");
    pulse_rb(1'b0, got);
    check(got, 1'b0, "R8 never rb_data");
    check(busy, 1'b0, "R8 never busy");
  endtask

  task automatic t_once();
    logic got;
    do_reset(2'b01);
    load_frames(8'h12, 8'h34, 8'h56, 8'h78);
    live_state = 8'hA3;
    run_readback(-1, "R9 one-time first");
    pulse_trig();
    check(busy, 1'b0, "R9 second trigger blocked");
    pulse_rb(1'b0, got);
    check(got, 1'b0, "R9 blocked rb_data");
    do_reset(2'b01);
    run_readback(-1, "R9 allowed again after reset");
  endtask

  initial begin
    t_reset();
    t_idle_edges();
    t_on_command();
    t_busy_trigger();
    t_never();
    t_once();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule